// File: doc/BRIEF.md
# Reaction Timer Controller

This block runs one round of a reaction-time game. A start pulse arms it while the mode input selects reaction play. It then waits out a pre-trigger delay with the LED dark. After the delay it lights the LED and counts time-base ticks on a four-digit decimal (BCD) counter. The player answers the light with a stop pulse, which freezes the digits so the reaction time can be read.

The delay length has two sources, chosen by a parameter. One is a constant cycle count. The other is a minimum cycle count plus the low bits of a 16-bit linear-feedback shift register, which advances on every clock. A stop pulse that arrives before the light counts as a false start: a one-cycle flag is raised, the digits stay at zero and the block goes back to idle. Display multiplexing, segment decoding and debouncing are handled elsewhere. Start, stop and tick arrive as clean single-cycle pulses in the clock domain.

Top module: `reaction_timer`

## Requirements
- R1: While `rst` is high, and immediately when it rises, the LED, the false-start flag and all four digits are zero and the block is idle.
- R2: A start pulse is accepted only when `mode` equals 2'b10 and the block is idle or stopped. A start pulse in any other mode, or while waiting or counting, changes no output.
- R3: With `RANDOM_EN`=0, the LED rises on the `FIXED_DELAY`-th rising edge after the edge that samples an accepted start.
- R4: With `RANDOM_EN`=1, the wait is `MIN_DELAY` plus the low `RAND_BITS` bits of the LFSR, sampled at the accepting edge. The LFSR resets to 16'hACE1 and shifts left on every clock. The new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10.
- R5: While counting, each tick pulse raises the displayed value by one. With no tick, the digits do not change.
- R6: Each digit holds 0 to 9. A digit that steps past 9 returns to 0 and carries into the next digit (`dig0` is least significant). 9999 steps to 0000.
- R7: A stop pulse while counting freezes the digits and leaves the LED lit. A tick in the same cycle as that stop is not counted. Later ticks are not counted either.
- R8: A stop pulse while waiting raises `false_start` for exactly the next cycle, keeps the LED off and the digits at zero, and returns the block to idle.
- R9: An accepted start clears the digits and the LED on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mode | input | 2 | Function select; 2'b10 selects reaction play |
| start | input | 1 | Single-cycle start pulse |
| stop | input | 1 | Single-cycle stop pulse |
| tick | input | 1 | Single-cycle time-base pulse |
| led | output | 1 | Lit from the end of the delay until the next start |
| false_start | output | 1 | One-cycle flag for a stop during the delay |
| dig0 | output | 4 | BCD digit, least significant |
| dig1 | output | 4 | BCD digit |
| dig2 | output | 4 | BCD digit |
| dig3 | output | 4 | BCD digit, most significant |

## Verification
The hardest case to reach from the ports is the full 9999-to-0000 wrap. It needs ten thousand counted ticks inside one round, so the stimulus arms a round, waits past the delay and then holds `tick` high for more than ten thousand cycles. The random delay also depends on where the LFSR is at the start edge. The bench tracks the register sequence from reset and arms several rounds at different times, so both short and long waits occur. A stop is then placed inside the wait to provoke a false start.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int NUM_DIGITS = 4;
    localparam logic [1:0] MODE_REACT = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2,
        ST_STOP  = 2'd3
    } rt_state_e;

    typedef struct packed {
        rt_state_e st;
        logic      led;
        logic      fs;
    } rt_ctl_t;
endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] q
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[W-2:0], ^(sr_q & TAPS)};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) sr_q <= SEED;
        else     sr_q <= sr_d;
    end

    assign q = sr_q;

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) sr_q != '0);
endmodule

// File: rtl/rt_delay.sv
module rt_delay #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         last
);
    logic [W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)
            rem_d = load_val;
        else if (run && rem_q > W'(1))
            rem_d = rem_q - W'(1);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) rem_q <= '0;
        else     rem_q <= rem_d;
    end

    assign last = (rem_q == W'(1));

    // R3
    delay_nonzero_chk: assert property (@(posedge clk) disable iff (rst) load |-> load_val != '0);
endmodule

// File: rtl/rt_bcd.sv
module rt_bcd #(
    parameter int NDIG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [NDIG*4-1:0] digs
);
    logic [NDIG:0] carry;
    assign carry[0] = inc;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [3:0] d_d, d_q;

        assign carry[i+1] = carry[i] && (d_q == 4'd9);

        always_comb begin
            d_d = d_q;
            if (clr)
                d_d = 4'd0;
            else if (carry[i])
                d_d = (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end

        always_ff @(posedge clk or posedge rst) begin
            if (rst) d_q <= 4'd0;
            else     d_q <= d_d;
        end

        assign digs[i*4 +: 4] = d_q;

        // R6
        digit_range_chk: assert property (@(posedge clk) disable iff (rst) d_q <= 4'd9);
    end
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
    import rt_pkg::*;
#(
    parameter int RANDOM_EN   = 0,
    parameter int FIXED_DELAY = 50000,
    parameter int MIN_DELAY   = 1000,
    parameter int RAND_BITS   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       start,
    input  logic       stop,
    input  logic       tick,
    output logic       led,
    output logic       false_start,
    output logic [3:0] dig0,
    output logic [3:0] dig1,
    output logic [3:0] dig2,
    output logic [3:0] dig3
);
    localparam int RAND_SPAN = (1 << RAND_BITS) - 1;
    localparam int LONGEST   = (FIXED_DELAY > MIN_DELAY + RAND_SPAN) ?
                               FIXED_DELAY : MIN_DELAY + RAND_SPAN;
    localparam int DLY_W     = $clog2(LONGEST + 1);

    rt_ctl_t ctl_d, ctl_q;
    logic load, clr, inc, dly_last;
    logic [DLY_W-1:0] dly_len;
    logic [NUM_DIGITS*4-1:0] digs;

    if (RANDOM_EN != 0) begin : g_rand
        logic [15:0] lfsr_q;
        rt_lfsr #(.W(16)) u_lfsr (.clk(clk), .rst(rst), .q(lfsr_q));
        assign dly_len = DLY_W'(MIN_DELAY) + DLY_W'(lfsr_q[RAND_BITS-1:0]);
    end else begin : g_fixed
        assign dly_len = DLY_W'(FIXED_DELAY);
    end

    rt_delay #(.W(DLY_W)) u_delay (
        .clk(clk), .rst(rst), .load(load), .load_val(dly_len),
        .run(ctl_q.st == ST_WAIT), .last(dly_last)
    );

    rt_bcd #(.NDIG(NUM_DIGITS)) u_bcd (
        .clk(clk), .rst(rst), .clr(clr), .inc(inc), .digs(digs)
    );

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.fs = 1'b0;
        load     = 1'b0;
        clr      = 1'b0;
        inc      = 1'b0;
        case (ctl_q.st)
            ST_IDLE, ST_STOP: begin
                if (start && mode == MODE_REACT) begin
                    ctl_d.st  = ST_WAIT;
                    ctl_d.led = 1'b0;
                    load      = 1'b1;
                    clr       = 1'b1;
                end
            end
            ST_WAIT: begin
                if (stop) begin
                    ctl_d.st = ST_IDLE;
                    ctl_d.fs = 1'b1;
                end else if (dly_last) begin
                    ctl_d.st  = ST_COUNT;
                    ctl_d.led = 1'b1;
                end
            end
            ST_COUNT: begin
                if (stop)      ctl_d.st = ST_STOP;
                else if (tick) inc = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ctl_q <= '{st: ST_IDLE, led: 1'b0, fs: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign led         = ctl_q.led;
    assign false_start = ctl_q.fs;
    assign dig0        = digs[3:0];
    assign dig1        = digs[7:4];
    assign dig2        = digs[11:8];
    assign dig3        = digs[15:12];

    // R3
    led_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.led) |-> $past(ctl_q.st == ST_WAIT));
    // R8
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.fs |-> (!ctl_q.led && digs == '0 && ctl_q.st == ST_IDLE));
    // R7
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_STOP && $past(ctl_q.st == ST_STOP)) |-> $stable(digs));
    // R2
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode != MODE_REACT && ctl_q.st == ST_IDLE) |=> ctl_q.st == ST_IDLE);
endmodule

// File: tb/sim_reaction_timer.sv
module sim_reaction_timer;
    localparam int CLK_P = 10;
    localparam int FIXED = 20;
    localparam int MIND  = 5;
    localparam int RBITS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic start = 1'b0, stop = 1'b0, tick = 1'b0;
    logic led_w [2];
    logic fs_w [2];
    logic [3:0] d_w [2][4];

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    reaction_timer #(.RANDOM_EN(0), .FIXED_DELAY(FIXED), .MIN_DELAY(MIND), .RAND_BITS(RBITS)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .start(start), .stop(stop), .tick(tick),
        .led(led_w[0]), .false_start(fs_w[0]),
        .dig0(d_w[0][0]), .dig1(d_w[0][1]), .dig2(d_w[0][2]), .dig3(d_w[0][3]));

    reaction_timer #(.RANDOM_EN(1), .FIXED_DELAY(FIXED), .MIN_DELAY(MIND), .RAND_BITS(RBITS)) u1 (
        .clk(clk), .rst(rst), .mode(mode), .start(start), .stop(stop), .tick(tick),
        .led(led_w[1]), .false_start(fs_w[1]),
        .dig0(d_w[1][0]), .dig1(d_w[1][1]), .dig2(d_w[1][2]), .dig3(d_w[1][3]));

    // reference model: 0 idle, 1 waiting, 2 counting, 3 stopped
    int m_st [2], m_rem [2], m_val [2];
    bit m_led [2], m_fs [2];
    logic [15:0] m_lfsr;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                m_st[k] = 0; m_rem[k] = 0; m_val[k] = 0; m_led[k] = 0; m_fs[k] = 0;
            end
            m_lfsr = 16'hACE1;
        end else begin
            for (int k = 0; k < 2; k++) begin
                m_fs[k] = 0;
                case (m_st[k])
                    0, 3: if (start && mode == 2'b10) begin
                        m_st[k]  = 1;
                        m_rem[k] = (k == 0) ? FIXED : MIND + int'(m_lfsr % (1 << RBITS));
                        m_led[k] = 0;
                        m_val[k] = 0;
                    end
                    1: if (stop) begin
                        m_st[k] = 0; m_fs[k] = 1;
                    end else if (m_rem[k] == 1) begin
                        m_st[k] = 2; m_led[k] = 1;
                    end else m_rem[k]--;
                    2: if (stop) m_st[k] = 3;
                       else if (tick) m_val[k] = (m_val[k] + 1) % 10000;
                    default: ;
                endcase
            end
            m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            for (int k = 0; k < 2; k++) begin
                checks++;
                if (led_w[k] !== m_led[k]) begin
                    fails++;
                    $display("FAIL %s u%0d led actual=%0b expected=%0b t=%0t", cur_req, k, led_w[k], m_led[k], $time);
                end
                checks++;
                if (fs_w[k] !== m_fs[k]) begin
                    fails++;
                    $display("FAIL %s u%0d false_start actual=%0b expected=%0b t=%0t", cur_req, k, fs_w[k], m_fs[k], $time);
                end
                for (int i = 0; i < 4; i++) begin
                    checks++;
                    if (d_w[k][i] !== 4'((m_val[k] / (10 ** i)) % 10)) begin
                        fails++;
                        $display("FAIL %s u%0d dig%0d actual=%0d expected=%0d t=%0t", cur_req, k, i,
                                 d_w[k][i], (m_val[k] / (10 ** i)) % 10, $time);
                    end
                end
            end
        end
    end

    task automatic drive(input bit s, input bit p, input bit t, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            start = s; stop = p; tick = t;
        end
    endtask

    task automatic pulse_start(input int idle_after);
        drive(1, 0, 0, 1);
        drive(0, 0, 0, idle_after);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        drive(0, 0, 0, 3);
        @(negedge clk); #(CLK_P/4) rst = 1'b0;
        drive(0, 0, 0, 2);

        // R2: start outside reaction mode is ignored
        cur_req = "R2";
        mode = 2'b01; pulse_start(4);
        mode = 2'b00; pulse_start(4);
        mode = 2'b11; pulse_start(4);
        mode = 2'b10;

        // R3 and R4: delays in both variants, then R5 counting with gaps
        cur_req = "R3";
        pulse_start(26);
        cur_req = "R5";
        drive(0, 0, 1, 3); drive(0, 0, 0, 2); drive(0, 0, 1, 1); drive(0, 0, 0, 3);
        // R2: start while counting ignored
        cur_req = "R2";
        pulse_start(2);
        // R7: stop freezes, later ticks ignored
        cur_req = "R7";
        drive(0, 1, 0, 1); drive(0, 0, 1, 5); drive(0, 0, 0, 2);

        // R9: new start clears; R7 stop with tick same cycle
        cur_req = "R9";
        pulse_start(26);
        drive(0, 0, 1, 4);
        cur_req = "R7";
        drive(0, 1, 1, 1); drive(0, 0, 1, 3); drive(0, 0, 0, 2);

        // R8: stop during the wait
        cur_req = "R8";
        pulse_start(2);
        drive(0, 1, 0, 1); drive(0, 0, 1, 4); drive(0, 0, 0, 3);

        // R4: several rounds at different LFSR positions
        cur_req = "R4";
        for (int r = 0; r < 6; r++) begin
            drive(0, 0, 0, r * 3 + 1);
            pulse_start(26);
            drive(0, 0, 1, r + 2);
            drive(0, 1, 0, 1); drive(0, 0, 0, 2);
        end

        // R6: full wrap through 9999
        cur_req = "R6";
        pulse_start(26);
        drive(0, 0, 1, 10012);
        drive(0, 1, 0, 1); drive(0, 0, 0, 3);

        // R1: asynchronous reset in the middle of a count
        cur_req = "R1";
        pulse_start(26);
        drive(0, 0, 1, 5);
        @(negedge clk); #(CLK_P/4) rst = 1'b1;
        drive(0, 0, 0, 2);
        @(negedge clk); #(CLK_P/4) rst = 1'b0;
        drive(0, 0, 0, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired at t=%0t", $time);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule